// File: doc/BRIEF.md
# Dual Compare/Capture Timer Channel

This block is one channel of a general-purpose timer: a free-running up-counter with two 16-bit slots, A and B. Each slot is switched on its own between a comparator, which flags the moment the counter equals the stored value, and a capture latch, which stores the counter value when a chosen edge arrives on that slot's external capture input. Two timer outputs are formed from the compare matches, each in one of four waveform modes and with an optional inversion at the pin.

Software reaches the channel through a small word-wide register port: a control word, the counter itself, the two slot values, an interrupt-enable word and an interrupt-flag word. Six events can raise the single interrupt line: a match on either slot, a capture on either slot, and a capture that lands while the previous capture on the same slot is still unacknowledged. Flags are acknowledged by writing ones.

Top module: `cct_chan`

## Requirements
- R1: The counter resets to 0, adds 1 on every clock while the run bit (control bit 0) is 1, wraps from 0xFFFF to 0, holds while run is 0, and takes the written value on a write to address 1 (a write overrides counting).
- R2: Control bits 1 (slot A) and 2 (slot B) select capture mode when 1 and compare mode when 0; both reset to compare mode. A slot in compare mode matches in a cycle where run is 1 and the counter equals the slot value, and the match sets its flag (flag bit 0 for A, bit 1 for B) on the following clock.
- R3: A slot in capture mode uses its 2-bit trigger field (bits 6:5 for A, 8:7 for B): 0 no capture, 1 rising edge, 2 falling edge, 3 both edges. The capture input passes two synchronizer flops, so the counter value in the third clock cycle after the input change is stored in the slot (address 2 for A, 3 for B) and sets the capture flag (bit 2 for A, bit 3 for B); edges not selected leave the slot value unchanged.
- R4: Output mode fields (bits 10:9 for output A, 12:11 for output B): 0 holds the waveform at 0, 1 sets it on a slot-A match and clears it on a slot-B match, 2 toggles it on every slot-A match, 3 toggles it on every slot-B match; the waveform changes on the clock after the match.
- R5: Control bits 3 (output A) and 4 (output B) invert the waveform at the pin; both outputs are 0 after reset.
- R6: A capture on a slot whose capture flag is already set, and not cleared by a write in that same cycle, sets that slot's overwrite flag (bit 4 for A, bit 5 for B) and still replaces the stored value.
- R7: Writing to the flag word (address 5) clears each flag whose data bit is 1 and leaves flags whose data bit is 0; an event that sets a flag in the same cycle as its clear wins.
- R8: The enable word (address 4) uses the same bit positions as the flags and resets to 0; the interrupt output is 1 exactly when some flag and its enable are both 1.
- R9: Register addresses: 0 control, 1 counter, 2 slot A, 3 slot B, 4 enables, 5 flags; addresses 6 and 7 read 0, control bits 15:13 and enable/flag bits 15:6 read 0, and every register resets to 0.
- R10: When a capture and a software write to the same slot fall in the same cycle, the captured counter value is stored.
- R11: In output mode 1, when slot A and slot B match in the same cycle, the output is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| cap_a_in | input | 1 | Capture input for slot A, asynchronous |
| cap_b_in | input | 1 | Capture input for slot B, asynchronous |
| tout_a | output | 1 | Timer output A |
| tout_b | output | 1 | Timer output B |
| irq | output | 1 | Combined interrupt request |

## Verification
The two collisions that matter are a capture landing in the same cycle as a software action on the same slot: a write to the slot value, and a write-one clear of the slot's capture flag. The bench raises a capture input, waits two clocks for the synchronizer, and issues the write on exactly the edge at which the capture fires; the slot must then hold the counter value and the flag must stay set without an overwrite flag. A match on both slots in one cycle under set/clear output mode is provoked by giving both slots the same value, and the output must end low. A behavioural model stepped every clock judges all outputs and the addressed register throughout, including a long stretch of random writes and capture toggles.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 6;

    // control word layout
    localparam int C_RUN   = 0;
    localparam int C_CAPM  = 1;   // + slot index
    localparam int C_INV   = 3;   // + output index
    localparam int C_TRIG  = 5;   // + 2 * slot index
    localparam int C_OMODE = 9;   // + 2 * output index
    localparam int CTRL_W  = 13;

    // flag / enable bit positions
    localparam int F_CMP = 0;     // + slot index
    localparam int F_CAP = 2;     // + slot index
    localparam int F_OVR = 4;     // + slot index

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_COUNT  = 3'd1,
        RA_DATA_A = 3'd2,
        RA_DATA_B = 3'd3,
        RA_IEN    = 3'd4,
        RA_FLAGS  = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        WM_OFF    = 2'd0,
        WM_SETCLR = 2'd1,
        WM_TOG_A  = 2'd2,
        WM_TOG_B  = 2'd3
    } wave_mode_e;

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise =  st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
    assign fall = ~st_q.chain[STAGES-1] &  st_q.chain[STAGES];

endmodule

// File: rtl/cct_slot.sv
module cct_slot import cct_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    input  logic             cap_mode,
    input  trig_e            trig,
    input  logic             edge_r,
    input  logic             edge_f,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] data,
    output logic             match,
    output logic             cap_ev
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } slot_st_t;

    slot_st_t st_q, st_d;
    logic     trig_hit;

    always_comb begin
        case (trig)
            TRIG_RISE: trig_hit = edge_r;
            TRIG_FALL: trig_hit = edge_f;
            TRIG_BOTH: trig_hit = edge_r | edge_f;
            default:   trig_hit = 1'b0;
        endcase
    end

    assign cap_ev = cap_mode & trig_hit;
    assign match  = run & ~cap_mode & (cnt == st_q.val);

    always_comb begin
        st_d = st_q;
        if (wr)     st_d.val = wdata;
        if (cap_ev) st_d.val = cnt;      // capture beats the bus (R10)
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.val;

    // R3 / R10: a capture stores the counter seen in that cycle, write or not
    p_cap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> data == $past(cnt));

    // R3: without capture or write the slot keeps its value
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_ev && !wr) |=> $stable(data));

endmodule

// File: rtl/cct_wave.sv
module cct_wave import cct_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  wave_mode_e mode,
    input  logic       invert,
    input  logic       hit_a,
    input  logic       hit_b,
    output logic       pin
);
    typedef struct packed {
        logic wave;
    } wave_st_t;

    wave_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (mode)
            WM_OFF:    st_d.wave = 1'b0;
            WM_SETCLR: begin
                if (hit_b)      st_d.wave = 1'b0;   // clear wins (R11)
                else if (hit_a) st_d.wave = 1'b1;
            end
            WM_TOG_A:  if (hit_a) st_d.wave = ~st_q.wave;
            WM_TOG_B:  if (hit_b) st_d.wave = ~st_q.wave;
            default:   st_d.wave = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.wave ^ invert;

    p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_OFF) |=> (pin == invert) || (mode != WM_OFF));

    p_toggle_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_TOG_A && hit_a) |=> (st_q.wave != $past(st_q.wave)));

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_SETCLR && hit_b) |=> !st_q.wave);

endmodule

// File: rtl/cct_chan.sv
module cct_chan import cct_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cap_a_in,
    input  logic              cap_b_in,
    output logic              tout_a,
    output logic              tout_b,
    output logic              irq
);
    localparam int NSLOT = 2;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [NFLAG-1:0]  ien;
        logic [NFLAG-1:0]  flg;
    } chan_st_t;

    chan_st_t          st_q, st_d;
    logic [NSLOT-1:0]  cap_in;
    logic [NSLOT-1:0]  edge_r, edge_f;
    logic [NSLOT-1:0]  match, cap_ev;
    logic [NSLOT-1:0]  pin;
    logic [CNT_W-1:0]  slot_data [NSLOT];
    logic [NFLAG-1:0]  clr, set;
    logic              run;
    logic              wr_ctrl, wr_cnt, wr_ien, wr_flg;

    assign cap_in  = {cap_b_in, cap_a_in};
    assign run     = st_q.ctrl[C_RUN];
    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_cnt  = bus_wr && (bus_addr == RA_COUNT);
    assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
    assign wr_flg  = bus_wr && (bus_addr == RA_FLAGS);
    assign clr     = wr_flg ? bus_wdata[NFLAG-1:0] : '0;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(RA_DATA_A) + ADDR_W'(g);

        cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (cap_in[g]),
            .rise  (edge_r[g]),
            .fall  (edge_f[g])
        );

        cct_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (st_q.cnt),
            .run      (run),
            .cap_mode (st_q.ctrl[C_CAPM + g]),
            .trig     (trig_e'(st_q.ctrl[C_TRIG + 2*g +: 2])),
            .edge_r   (edge_r[g]),
            .edge_f   (edge_f[g]),
            .wr       (bus_wr && (bus_addr == SLOT_ADDR)),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .data     (slot_data[g]),
            .match    (match[g]),
            .cap_ev   (cap_ev[g])
        );

        cct_wave u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (wave_mode_e'(st_q.ctrl[C_OMODE + 2*g +: 2])),
            .invert (st_q.ctrl[C_INV + g]),
            .hit_a  (match[0]),
            .hit_b  (match[1]),
            .pin    (pin[g])
        );
    end

    // event sources for the flag word
    always_comb begin
        set = '0;
        for (int i = 0; i < NSLOT; i++) begin
            set[F_CMP + i] = match[i];
            set[F_CAP + i] = cap_ev[i];
            set[F_OVR + i] = cap_ev[i] & st_q.flg[F_CAP + i] & ~clr[F_CAP + i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = bus_wdata[CTRL_W-1:0];
        if (run)     st_d.cnt  = st_q.cnt + CNT_W'(1);
        if (wr_cnt)  st_d.cnt  = bus_wdata[CNT_W-1:0];
        if (wr_ien)  st_d.ien  = bus_wdata[NFLAG-1:0];
        st_d.flg = (st_q.flg & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            RA_CTRL:   bus_rdata = BUS_W'(st_q.ctrl);
            RA_COUNT:  bus_rdata = BUS_W'(st_q.cnt);
            RA_DATA_A: bus_rdata = BUS_W'(slot_data[0]);
            RA_DATA_B: bus_rdata = BUS_W'(slot_data[1]);
            RA_IEN:    bus_rdata = BUS_W'(st_q.ien);
            RA_FLAGS:  bus_rdata = BUS_W'(st_q.flg);
            default:   bus_rdata = '0;
        endcase
    end

    assign tout_a = pin[0];
    assign tout_b = pin[1];
    assign irq    = |(st_q.flg & st_q.ien);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));

    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(st_q.cnt));

    p_match_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match[0] |=> st_q.flg[F_CMP]);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flg && bus_wdata[F_CMP] && !match[0]) |=> !st_q.flg[F_CMP]);

    p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev[0] && st_q.flg[F_CAP] && !clr[F_CAP]) |=> st_q.flg[F_OVR]);

endmodule

// File: tb/tb_cct_chan.sv
module tb_cct_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cap_a_in = 1'b0;
    logic        cap_b_in = 1'b0;
    logic        tout_a, tout_b, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int cyc = 0;

    // reference model state
    logic [15:0] m_ctrl, m_cnt, m_da, m_db;
    logic [5:0]  m_ien, m_flg;
    logic [1:0]  m_wave;
    logic [2:0]  m_sa, m_sb;

    always #5 clk = ~clk;

    cct_chan dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_a_in(cap_a_in),
        .cap_b_in(cap_b_in), .tout_a(tout_a), .tout_b(tout_b), .irq(irq)
    );

    function automatic logic fire(logic [1:0] trig, logic prev, logic cur);
        logic r, f;
        r = cur & ~prev;
        f = ~cur & prev;
        case (trig)
            2'd1: return r;
            2'd2: return f;
            2'd3: return r | f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cnt;
            3'd2: return m_da;
            3'd3: return m_db;
            3'd4: return {10'd0, m_ien};
            3'd5: return {10'd0, m_flg};
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R9";
            3'd1: return "R1";
            3'd2, 3'd3: return "R3";
            3'd4: return "R8";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 0; m_cnt = 0; m_da = 0; m_db = 0;
        m_ien = 0; m_flg = 0; m_wave = 0; m_sa = 0; m_sb = 0;
    endtask

    task automatic model_step();
        logic       run;
        logic [1:0] hit, cap;
        logic [5:0] clr, nflg;
        logic [1:0] nwave;
        logic [15:0] nda, ndb, ncnt, nctrl;
        if (!rst_n) begin
            model_reset();
            return;
        end
        run    = m_ctrl[0];
        hit[0] = run && !m_ctrl[1] && (m_cnt == m_da);
        hit[1] = run && !m_ctrl[2] && (m_cnt == m_db);
        cap[0] = m_ctrl[1] && fire(m_ctrl[6:5], m_sa[2], m_sa[1]);
        cap[1] = m_ctrl[2] && fire(m_ctrl[8:7], m_sb[2], m_sb[1]);
        clr    = (bus_wr && bus_addr == 3'd5) ? bus_wdata[5:0] : 6'd0;
        nflg   = m_flg & ~clr;
        for (int i = 0; i < 2; i++) begin
            if (hit[i]) nflg[i] = 1'b1;
            if (cap[i]) nflg[2+i] = 1'b1;
            if (cap[i] && m_flg[2+i] && !clr[2+i]) nflg[4+i] = 1'b1;
        end
        nwave = m_wave;
        for (int i = 0; i < 2; i++) begin
            case (m_ctrl[9+2*i +: 2])
                2'd0: nwave[i] = 1'b0;
                2'd1: if (hit[1]) nwave[i] = 1'b0; else if (hit[0]) nwave[i] = 1'b1;
                2'd2: if (hit[0]) nwave[i] = ~m_wave[i];
                default: if (hit[1]) nwave[i] = ~m_wave[i];
            endcase
        end
        nda = m_da; ndb = m_db; nctrl = m_ctrl;
        ncnt = run ? m_cnt + 16'd1 : m_cnt;
        if (bus_wr) begin
            case (bus_addr)
                3'd0: nctrl = bus_wdata & 16'h1FFF;
                3'd1: ncnt = bus_wdata;
                3'd2: nda = bus_wdata;
                3'd3: ndb = bus_wdata;
                3'd4: m_ien = bus_wdata[5:0];
                default: ;
            endcase
        end
        if (cap[0]) nda = m_cnt;
        if (cap[1]) ndb = m_cnt;
        m_sa = {m_sa[1:0], cap_a_in};
        m_sb = {m_sb[1:0], cap_b_in};
        m_ctrl = nctrl; m_cnt = ncnt; m_da = nda; m_db = ndb;
        m_flg = nflg; m_wave = nwave;
    endtask

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk(tag_of(bus_addr), $sformatf("read addr %0d", bus_addr), bus_rdata, m_read(bus_addr));
        chk("R4", "tout_a", {15'd0, tout_a}, {15'd0, m_wave[0] ^ m_ctrl[3]});
        chk("R5", "tout_b", {15'd0, tout_b}, {15'd0, m_wave[1] ^ m_ctrl[4]});
        chk("R8", "irq", {15'd0, irq}, {15'd0, |(m_flg & m_ien)});
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            bus_wr = 1'b0;
            bus_addr = 3'(cyc % 8);
            step();
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(logic [2:0] a, logic [15:0] exp, string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, $sformatf("directed read addr %0d", a), bus_rdata, exp);
    endtask

    function automatic logic [15:0] mk(logic r, logic ca, logic cb, logic ia, logic ib,
                                       logic [1:0] ta, logic [1:0] tb, logic [1:0] oa, logic [1:0] ob);
        return {3'd0, ob, oa, tb, ta, ib, ia, cb, ca, r};
    endfunction

    initial begin
        repeat (1000) begin
            @(posedge clk);
            if (done) break;
        end
        repeat (150000) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state (R9, R5, R2)
        for (int a = 0; a < 8; a++) expect_rd(3'(a), 16'd0, "R9");
        chk("R5", "tout_a after reset", {15'd0, tout_a}, 16'd0);
        chk("R8", "irq after reset", {15'd0, irq}, 16'd0);

        // reserved control bits (R9)
        wr(3'd0, 16'hFFFF);
        expect_rd(3'd0, 16'h1FFF, "R9");
        wr(3'd4, 16'hFFFF);
        expect_rd(3'd4, 16'h003F, "R9");
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'hFFFF);

        // counter wrap and hold (R1), matches at zero (R2)
        wr(3'd2, 16'd0); wr(3'd3, 16'd0);
        wr(3'd1, 16'hFFFD);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
        idle(4);
        expect_rd(3'd1, 16'h0001, "R1");
        expect_rd(3'd5, 16'h0003, "R2");
        wr(3'd0, 16'h0000);
        idle(3);
        expect_rd(3'd1, 16'h0002, "R1");
        wr(3'd5, 16'h003F);

        // compare waveforms (R2, R4, R5, R8)
        wr(3'd2, 16'd10); wr(3'd3, 16'd20); wr(3'd1, 16'd0); wr(3'd4, 16'h0003);
        wr(3'd0, mk(1, 0, 0, 0, 1, 0, 0, 2'd1, 2'd2));
        idle(30);
        expect_rd(3'd5, 16'h0003, "R2");
        chk("R4", "set/clear output after both matches", {15'd0, tout_a}, 16'd0);
        chk("R5", "inverted toggled output", {15'd0, tout_b}, 16'd0);
        chk("R8", "irq with enabled flags", {15'd0, irq}, 16'd1);
        wr(3'd5, 16'h0001);
        expect_rd(3'd5, 16'h0002, "R7");
        wr(3'd5, 16'h0000);
        expect_rd(3'd5, 16'h0002, "R7");
        wr(3'd4, 16'h0000);
        chk("R8", "irq with enables off", {15'd0, irq}, 16'd0);

        // same-cycle double match in set/clear mode (R11)
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 2'd1, 2'd3));
        wr(3'd1, 16'd45); wr(3'd2, 16'd50); wr(3'd3, 16'd200);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 2'd1, 2'd3));
        idle(8);
        chk("R4", "output set by slot A match", {15'd0, tout_a}, 16'd1);
        wr(3'd2, 16'd60); wr(3'd3, 16'd60);
        idle(10);
        chk("R11", "double match clears output", {15'd0, tout_a}, 16'd0);

        // capture (R3, R6)
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h003F);
        wr(3'd1, 16'h1234);
        wr(3'd4, 16'h003C);
        wr(3'd0, mk(0, 1, 1, 0, 0, 2'd1, 2'd3, 0, 0));
        cap_a_in = 1'b1; idle(4);
        expect_rd(3'd2, 16'h1234, "R3");
        expect_rd(3'd5, 16'h0004, "R3");
        chk("R8", "irq on capture", {15'd0, irq}, 16'd1);
        wr(3'd1, 16'h2222);
        cap_a_in = 1'b0; idle(4);
        expect_rd(3'd2, 16'h1234, "R3");
        cap_a_in = 1'b1; idle(4);
        expect_rd(3'd2, 16'h2222, "R6");
        expect_rd(3'd5, 16'h0014, "R6");
        cap_b_in = 1'b1; idle(4);
        expect_rd(3'd3, 16'h2222, "R3");
        wr(3'd1, 16'h3333);
        cap_b_in = 1'b0; idle(4);
        expect_rd(3'd3, 16'h3333, "R3");
        expect_rd(3'd5, 16'h003C, "R6");

        // capture vs bus write, capture vs flag clear (R10, R7)
        wr(3'd5, 16'h003F);
        wr(3'd1, 16'h4444);
        cap_b_in = 1'b1; bus_addr = 3'd3; step(); step();
        wr(3'd3, 16'h0BAD);
        expect_rd(3'd3, 16'h4444, "R10");
        expect_rd(3'd5, 16'h0008, "R10");
        cap_b_in = 1'b0; bus_addr = 3'd5; step(); step();
        wr(3'd5, 16'h0008);
        expect_rd(3'd5, 16'h0008, "R7");

        // random traffic judged by the model every cycle
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0) cap_a_in = ~cap_a_in;
            if ($urandom_range(0, 7) == 0) cap_b_in = ~cap_b_in;
            if ($urandom_range(0, 3) == 0) begin
                logic [2:0] a;
                logic [15:0] d;
                a = 3'($urandom_range(0, 7));
                d = 16'($urandom);
                if (a == 3'd0) d[0] = 1'b1;
                if (a == 3'd2 || a == 3'd3) d = {8'd0, d[7:0]};
                wr(a, d);
            end else begin
                idle(1);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule